// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel of a general-purpose timer. A raw input is picked from a bank of sixteen lines, brought into the clock domain by two flip-flops, and cleaned by a digital glitch filter. The filter runs on a sample strobe and accepts a new level only after a run of equal samples. Rising and falling pulses taken from the filtered level are combined under a polarity setting to form the channel's own trigger. That trigger is always sent out toward a slave controller.

A capture source multiplexer picks one event stream: the channel's own trigger, the edges of the neighbouring channel (under the same polarity setting), or an internal trigger pulse. An event divider passes every 1st, 2nd, 4th or 8th event. Each event it passes copies the free-running counter value into the capture register and raises a capture flag. If the flag is still set when the next capture arrives, an over-capture flag is raised too.

Top module: `capture_channel`

## Requirements
- R1: `in_sel` value 0 routes `pin_in` to the filter, and a value k from 1 to 15 routes `alt_in[k]`. No other line has any effect.
- R2: With `filt_cfg` nonzero, the filtered level takes a new input value only after N consecutive sample strobes see that value. N is 2, 4, 5 or 6 for codes 1, 2, 3 or 4, and N is 8 for codes 5 to 15. A run shorter than N is dropped. Code 0 bypasses the filter, so a one-cycle input pulse gets through.
- R3: With `filt_cfg` nonzero and `samp_en` low, the filtered level does not change.
- R4: `pol_cfg` selects the active edge of the filtered level. 00 selects the rising edge, 01 the falling edge and 11 both edges. 10 behaves like 00.
- R5: `trig_out` pulses on each active own edge, whatever the values of `src_sel` and `cap_en`.
- R6: `src_sel` chooses the capture event. 01 selects the own trigger and 10 selects `nbr_rise`/`nbr_fall` under `pol_cfg`. 11 selects `itrig`. 00 makes no captures.
- R7: `psc_cfg` values 00, 01, 10 and 11 make a capture on every 1st, 2nd, 4th and 8th selected event, respectively.
- R8: While `cap_en` is low, no capture happens, and the event divider count returns to zero.
- R9: A capture loads `cnt_val` into `cap_val` and sets `cap_flag`. `flag_clr` clears both flags, unless a capture takes place in the same cycle.
- R10: A capture that happens while `cap_flag` is already set also sets `ovr_flag`.
- R11: Any change of `psc_cfg` returns the event divider count to zero.
- R12: After reset, `cap_val`, `cap_flag`, `ovr_flag` and `trig_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer kernel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_en | input | 1 | Filter sample strobe |
| pin_in | input | 1 | Channel's own input line |
| alt_in | input | 15 | Alternate input lines 1 to 15 |
| in_sel | input | 4 | Input line select |
| filt_cfg | input | 4 | Filter length code |
| pol_cfg | input | 2 | Active edge select |
| nbr_rise | input | 1 | Neighbour filtered rising-edge pulse |
| nbr_fall | input | 1 | Neighbour filtered falling-edge pulse |
| itrig | input | 1 | Internal trigger pulse |
| src_sel | input | 2 | Capture source select |
| psc_cfg | input | 2 | Event divider setting |
| cap_en | input | 1 | Capture enable |
| flag_clr | input | 1 | Clears capture and over-capture flags |
| cnt_val | input | 16 | Free-running counter value |
| cap_val | output | 16 | Captured counter value |
| cap_flag | output | 1 | Capture occurred |
| ovr_flag | output | 1 | Capture occurred with flag already set |
| trig_out | output | 1 | Own edge trigger toward slave controller |

## Verification
The bench sweeps all sixteen filter codes. For each code it sends a pulse one sample shorter than the run length, then one exactly as long. An off-by-one in the run counter therefore either passes a glitch or swallows a valid edge. The divider is run with thirteen events at each setting, so a wrong terminal count shows up as a wrong captured value and a wrong number of captures. The divider count is left part-way through a cycle before `cap_en` is dropped or `psc_cfg` is changed. A design that keeps the stale count then captures too early. The bench also checks the polarity modes, including both-edge mode, and checks `trig_out` with capture switched off. A design that ties the trigger to the capture path, or that loses one edge in both-edge mode, is caught.

// File: rtl/capture_channel.sv
module capture_channel #(
  parameter int CW  = 16,
  parameter int ALT = 15,
  localparam int SW = $clog2(ALT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_en,
  input  logic          pin_in,
  input  logic [ALT:1]  alt_in,
  input  logic [SW-1:0] in_sel,
  input  logic [3:0]    filt_cfg,
  input  logic [1:0]    pol_cfg,
  input  logic          nbr_rise,
  input  logic          nbr_fall,
  input  logic          itrig,
  input  logic [1:0]    src_sel,
  input  logic [1:0]    psc_cfg,
  input  logic          cap_en,
  input  logic          flag_clr,
  input  logic [CW-1:0] cnt_val,
  output logic [CW-1:0] cap_val,
  output logic          cap_flag,
  output logic          ovr_flag,
  output logic          trig_out
);

  function automatic logic [3:0] run_len(input logic [3:0] code);
    case (code)
      4'd0:    run_len = 4'd1;
      4'd1:    run_len = 4'd2;
      4'd2:    run_len = 4'd4;
      4'd3:    run_len = 4'd5;
      4'd4:    run_len = 4'd6;
      default: run_len = 4'd8;
    endcase
  endfunction

  function automatic logic pick_edge(input logic [1:0] pol, input logic r, input logic f);
    case (pol)
      2'b01:   pick_edge = f;
      2'b11:   pick_edge = r | f;
      default: pick_edge = r;
    endcase
  endfunction

  logic [ALT:0] lines;
  logic         s1, s2, lvl, lvl_d;
  logic [3:0]   run;
  logic [2:0]   psc_cnt;
  logic [1:0]   psc_q;
  logic         own_ev, nbr_ev, ev, hit;
  logic [2:0]   div_m1;

  assign lines  = {alt_in, pin_in};
  assign own_ev = pick_edge(pol_cfg, lvl & ~lvl_d, ~lvl & lvl_d);
  assign nbr_ev = pick_edge(pol_cfg, nbr_rise, nbr_fall);
  assign trig_out = own_ev;
  assign div_m1 = 3'((4'd1 << psc_cfg) - 4'd1);

  always_comb begin
    case (src_sel)
      2'b01:   ev = own_ev;
      2'b10:   ev = nbr_ev;
      2'b11:   ev = itrig;
      default: ev = 1'b0;
    endcase
  end

  assign hit = cap_en && ev && (psc_cnt == div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      lvl   <= 1'b0;
      lvl_d <= 1'b0;
      run   <= '0;
    end else begin
      s1    <= lines[in_sel];
      s2    <= s1;
      lvl_d <= lvl;
      if (filt_cfg == 4'd0) begin
        lvl <= s2;
        run <= '0;
      end else if (samp_en) begin
        if (s2 == lvl) begin
          run <= '0;
        end else if (run + 4'd1 >= run_len(filt_cfg)) begin
          lvl <= s2;
          run <= '0;
        end else begin
          run <= run + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_cnt  <= '0;
      psc_q    <= '0;
      cap_val  <= '0;
      cap_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      psc_q <= psc_cfg;
      if (!cap_en || psc_cfg != psc_q) psc_cnt <= '0;
      else if (ev) psc_cnt <= hit ? 3'd0 : psc_cnt + 3'd1;
      if (hit) begin
        cap_val  <= cnt_val;
        cap_flag <= 1'b1;
        ovr_flag <= ovr_flag | cap_flag;
      end else if (flag_clr) begin
        cap_flag <= 1'b0;
        ovr_flag <= 1'b0;
      end
    end
  end

endmodule

module capture_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_en,
  input logic [1:0]    src_sel,
  input logic          flag_clr,
  input logic [CW-1:0] cap_val,
  input logic          cap_flag,
  input logic          ovr_flag
);

  a_r8_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(cap_val) && !$rose(cap_flag));

  a_r6_no_source: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel == 2'b00 |=> $stable(cap_val) && !$rose(cap_flag));

  a_r10_ovr_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(cap_flag));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && src_sel == 2'b00) |=> !cap_flag && !ovr_flag);

  a_r9_value_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_val) |-> cap_flag);

endmodule

bind capture_channel capture_channel_chk #(.CW(CW)) u_chk (.*);

// File: tb/sim_capture_channel.sv
`timescale 1ns/1ps
module sim_capture_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_en = 1'b1;
  logic        pin_in = 1'b0;
  logic [15:1] alt_in = '0;
  logic [3:0]  in_sel = '0;
  logic [3:0]  filt_cfg = '0;
  logic [1:0]  pol_cfg = '0;
  logic        nbr_rise = 1'b0, nbr_fall = 1'b0, itrig = 1'b0;
  logic [1:0]  src_sel = 2'b01;
  logic [1:0]  psc_cfg = '0;
  logic        cap_en = 1'b1;
  logic        flag_clr = 1'b0;
  logic [15:0] cnt_val = '0;
  logic [15:0] cap_val;
  logic        cap_flag, ovr_flag, trig_out;

  int nchk = 0, nfail = 0;
  int trig_cnt = 0, cap_cnt = 0;
  logic [15:0] prev_cap = '0;

  always #2.5 clk = ~clk;

  capture_channel u0 (.*);

  always @(negedge clk) begin
    if (trig_out) trig_cnt <= trig_cnt + 1;
    if (cap_val != prev_cap) cap_cnt <= cap_cnt + 1;
    prev_cap <= cap_val;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setline(int idx, logic v);
    if (idx == 0) pin_in = v;
    else alt_in[idx] = v;
  endtask

  task automatic clr();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0; tick(1);
  endtask

  task automatic pulse_it(logic [15:0] v);
    cnt_val = v; itrig = 1'b1; tick(1); itrig = 1'b0; tick(2);
  endtask

  function automatic int exp_len(int c);
    if (c == 0) return 1;
    if (c <= 2) return 1 << c;
    if (c <= 4) return c + 2;
    return 8;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int t0, c0;
    tick(3);
    // R12 reset state
    chk("R12 cap_val", cap_val, 0);
    chk("R12 cap_flag", cap_flag, 0);
    chk("R12 ovr_flag", ovr_flag, 0);
    chk("R12 trig_out", trig_out, 0);
    rst_n = 1'b1;
    tick(3);

    // R1 input select sweep
    for (int k = 0; k < 16; k++) begin
      in_sel = 4'(k);
      tick(4); clr();
      cnt_val = 16'd999;
      setline((k + 1) % 16, 1'b1); tick(3); setline((k + 1) % 16, 1'b0); tick(8);
      chk("R1 other line ignored", cap_flag, 0);
      cnt_val = 16'(100 + k);
      setline(k, 1'b1); tick(3); setline(k, 1'b0); tick(8);
      chk("R1 selected line flag", cap_flag, 1);
      chk("R1 selected line value", cap_val, 100 + k);
    end
    in_sel = '0;

    // R2 filter run-length sweep
    for (int c = 0; c < 16; c++) begin
      int n;
      n = exp_len(c);
      filt_cfg = 4'(c);
      tick(12); clr();
      if (n > 1) begin
        cnt_val = 16'd500;
        pin_in = 1'b1; tick(n - 1); pin_in = 1'b0; tick(12);
        chk("R2 short run dropped", cap_flag, 0);
      end
      cnt_val = 16'(c + 1);
      pin_in = 1'b1; tick(n); pin_in = 1'b0; tick(14);
      chk("R2 full run accepted", cap_flag, 1);
      chk("R2 full run value", cap_val, c + 1);
    end

    // R3 sample strobe off freezes filter
    filt_cfg = 4'd3; samp_en = 1'b0; clr();
    pin_in = 1'b1; tick(20); pin_in = 1'b0; tick(20);
    chk("R3 frozen filter no capture", cap_flag, 0);
    samp_en = 1'b1; filt_cfg = 4'd0; tick(4);

    // R4 polarity modes
    for (int p = 0; p < 4; p++) begin
      int ec, ev;
      pol_cfg = 2'(p); tick(2); clr();
      t0 = trig_cnt; c0 = cap_cnt;
      cnt_val = 16'd1; pin_in = 1'b1; tick(8);
      cnt_val = 16'd2; pin_in = 1'b0; tick(8);
      ec = (p == 3) ? 2 : 1;
      ev = (p == 1 || p == 3) ? 2 : 1;
      chk("R4 edge count", trig_cnt - t0, ec);
      chk("R4 captured value", cap_val, ev);
    end
    pol_cfg = 2'b00;

    // R5 trigger out with capture path off
    src_sel = 2'b00; cap_en = 1'b0; clr();
    t0 = trig_cnt; c0 = cap_cnt;
    cnt_val = 16'd77; pin_in = 1'b1; tick(8); pin_in = 1'b0; tick(8);
    chk("R5 trig_out pulses", trig_cnt - t0, 1);
    chk("R6/R8 no capture", cap_cnt - c0, 0);
    cap_en = 1'b1; src_sel = 2'b01; tick(2);

    // R6 neighbour and internal sources
    src_sel = 2'b10; clr();
    cnt_val = 16'd55; nbr_rise = 1'b1; tick(1); nbr_rise = 1'b0; tick(3);
    chk("R6 neighbour rise", cap_val, 55);
    cnt_val = 16'd56; nbr_fall = 1'b1; tick(1); nbr_fall = 1'b0; tick(3);
    chk("R6 neighbour fall ignored under rising", cap_val, 55);
    pol_cfg = 2'b01;
    cnt_val = 16'd57; nbr_fall = 1'b1; tick(1); nbr_fall = 1'b0; tick(3);
    chk("R6 neighbour fall under falling", cap_val, 57);
    pol_cfg = 2'b00; src_sel = 2'b11;
    cnt_val = 16'd60; pin_in = 1'b1; tick(8); pin_in = 1'b0; tick(8);
    chk("R6 own edge ignored on itrig source", cap_val, 57);
    pulse_it(16'd61);
    chk("R6 itrig capture", cap_val, 61);
    src_sel = 2'b01;
    cnt_val = 16'd62; nbr_rise = 1'b1; tick(1); nbr_rise = 1'b0; tick(3);
    chk("R6 neighbour ignored on own source", cap_val, 61);

    // R7 event divider
    src_sel = 2'b11;
    for (int p = 0; p < 4; p++) begin
      int d;
      d = 1 << p;
      cap_en = 1'b0; psc_cfg = 2'(p); tick(2); cap_en = 1'b1; clr();
      c0 = cap_cnt;
      for (int i = 1; i <= 13; i++) pulse_it(16'(1000 * (p + 1) + i));
      tick(2);
      chk("R7 capture count", cap_cnt - c0, 13 / d);
      chk("R7 last value", cap_val, 1000 * (p + 1) + (13 / d) * d);
    end

    // R8 disable clears divider
    cap_en = 1'b0; psc_cfg = 2'd2; tick(2); cap_en = 1'b1; tick(1);
    c0 = cap_cnt;
    for (int i = 0; i < 3; i++) pulse_it(16'(2000 + i));
    cap_en = 1'b0; tick(1); cap_en = 1'b1; tick(1);
    for (int i = 3; i < 6; i++) pulse_it(16'(2000 + i));
    chk("R8 divider cleared by disable", cap_cnt - c0, 0);
    pulse_it(16'd2006);
    chk("R8 capture on 4th after enable", cap_val, 2006);

    // R11 divider cleared on setting change
    cap_en = 1'b0; tick(1); cap_en = 1'b1; tick(1);
    c0 = cap_cnt;
    for (int i = 0; i < 3; i++) pulse_it(16'(3000 + i));
    psc_cfg = 2'd3; tick(2);
    for (int i = 3; i < 10; i++) pulse_it(16'(3000 + i));
    chk("R11 no early capture", cap_cnt - c0, 0);
    pulse_it(16'd3010);
    chk("R11 capture on 8th after change", cap_val, 3010);

    // R9 / R10 flags
    cap_en = 1'b0; psc_cfg = 2'd0; tick(2); cap_en = 1'b1; clr();
    chk("R9 flag cleared", cap_flag, 0);
    chk("R9 ovr cleared", ovr_flag, 0);
    pulse_it(16'd4001);
    chk("R9 flag set", cap_flag, 1);
    chk("R10 no ovr on first", ovr_flag, 0);
    pulse_it(16'd4002);
    chk("R10 ovr set", ovr_flag, 1);
    chk("R9 value", cap_val, 4002);
    clr();
    chk("R9 flag_clr flag", cap_flag, 0);
    chk("R9 flag_clr ovr", ovr_flag, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule